// File: doc/BRIEF.md
# Serial Result Port with Interrupt

This block sits between a frequency-measurement core and a host processor. The core hands it a fresh result word together with a one-cycle load strobe. The block keeps the newest word, signals the host through an open-drain interrupt, and lets the host read the word over a three-wire link made of an active-low select, a serial clock and a data line. The most significant bit is the band flag. It is readable as soon as select takes effect. Each rising serial clock then moves to the next lower bit, and once the word is used up the data line reads zero.

Select and serial clock arrive from the host without any relation to the system clock. Each passes through a synchronizer chain, and edges are found in the system clock domain. While the host holds select low, the stored word cannot change. A result that arrives during that time is parked and is applied as soon as select returns high. The data pin's tri-state is modelled as a value plus an output enable. The interrupt is modelled as a pull-down enable. A freeze input from the core marks the decoder as disabled. While it is high, new results are refused and the data line shows the stored band bit.

Top module: `serial_result_port`

## Requirements
- R1: After reset the output enable is low, the interrupt pull-down is released (irq_pull = 0) and the stored word is all zeros.
- R2: A load strobe while the synchronized select is high (deselected) and freeze is low stores the word and sets irq_pull = 1 from the next clock.
- R3: While selected, sdo first shows bit WORD_W-1 of the stored word. Each synchronized rising edge of sclk_in then moves one bit lower, most significant bit first.
- R4: After WORD_W bits have been presented, every further serial clock edge leaves sdo at 0. With WORD_W = 6 and 8 clocks, the last two bits read 0.
- R5: Whenever the synchronized select is low, irq_pull is cleared on the next clock and stays cleared until select goes high again.
- R6: A load strobe while selected leaves the stored word and irq_pull unchanged. The word is applied, and irq_pull is set, on the first clock on which the synchronized select is high.
- R7: A newer result replaces an unread one, both in the stored word and in a parked result.
- R8: While dec_off is high, load strobes and parked results are not applied, and sdo (when enabled) equals the stored bit WORD_W-1 whatever the serial clocks do.
- R9: While deselected, sdo_oe is 0 and sdo is 0.
- R10: csn_in and sclk_in pass through SYNC_STAGES flops. sdo_oe rises exactly SYNC_STAGES clocks after csn_in is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| res_word | input | WORD_W | Result word from the measurement core, band flag in the top bit |
| res_load | input | 1 | One-cycle strobe that offers res_word |
| dec_off | input | 1 | Decoder disabled: refuse loads and freeze the data line |
| csn_in | input | 1 | Host chip select, active low, asynchronous |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for sdo (tri-state model) |
| irq_pull | output | 1 | Interrupt pull-down enable; 1 drives the line low |

## Verification
The bench uses the default values WORD_W = 6 and SYNC_STAGES = 2. This makes the six-bit band-plus-count word and the two padding zeros of an eight-clock read directly observable, and makes the two-clock select latency exactly countable. The short synchronizer lets a result be parked in the middle of a read and released a few cycles after deselect, within a short run. Frozen reads and overwrites of unread words are covered against a per-clock behavioural model.

// File: rtl/srp_pkg.sv
package srp_pkg;

    // Default geometry: one band flag plus a five-bit count.
    localparam int DEF_WORD_W = 6;
    localparam int DEF_SYNC   = 2;

    // A host line after synchronization, with its edges.
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } line_t;

    // Width of a pointer that can reach the value n.
    function automatic int ptr_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync
    import srp_pkg::*;
#(
    parameter int   STAGES  = DEF_SYNC,
    parameter logic RST_VAL = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  d,
    output line_t q
);

    logic [STAGES-1:0] chain;
    logic              last;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= RST_VAL;
        else     last <= chain[STAGES-1];
    end

    always_comb begin
        q.lvl  = chain[STAGES-1];
        q.rise = chain[STAGES-1] & ~last;
        q.fall = ~chain[STAGES-1] & last;
    end

endmodule

// File: rtl/srp_hold.sv
module srp_hold #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         frz,
    input  logic         sel,
    output logic [W-1:0] word_q,
    output logic         irq_q
);

    logic         park_q;
    logic [W-1:0] park_word_q;
    logic         take_new;
    logic         take_park;
    logic         park_new;

    always_comb begin
        take_new  = load & ~frz & ~sel;
        park_new  = load & ~frz & sel;
        take_park = ~load & ~frz & ~sel & park_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q      <= '0;
            park_q      <= 1'b0;
            park_word_q <= '0;
        end else begin
            if (take_new) begin
                word_q <= din;
                park_q <= 1'b0;
            end else if (take_park) begin
                word_q <= park_word_q;
                park_q <= 1'b0;
            end
            if (park_new) begin
                park_q      <= 1'b1;
                park_word_q <= din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                       irq_q <= 1'b0;
        else if (sel)                  irq_q <= 1'b0;
        else if (take_new | take_park) irq_q <= 1'b1;
    end

endmodule

// File: rtl/srp_ptr.sv
module srp_ptr
    import srp_pkg::*;
#(
    parameter int W  = 6,
    parameter int PW = ptr_bits(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic         adv,
    input  logic         frz,
    input  logic [W-1:0] word,
    output logic [PW-1:0] ptr_q,
    output logic         sdo,
    output logic         sdo_oe
);

    localparam logic [PW-1:0] LAST = PW'(W);

    logic [W-1:0] view;

    always_ff @(posedge clk) begin
        if (rst)                        ptr_q <= '0;
        else if (!sel)                  ptr_q <= '0;
        else if (adv && ptr_q != LAST)  ptr_q <= ptr_q + 1'b1;
    end

    always_comb begin
        view   = word << ptr_q;
        sdo_oe = sel;
        if (!sel)     sdo = 1'b0;
        else if (frz) sdo = word[W-1];
        else          sdo = view[W-1];
    end

endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
    import srp_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] res_word,
    input  logic              res_load,
    input  logic              dec_off,
    input  logic              csn_in,
    input  logic              sclk_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              irq_pull
);

    localparam int PW = ptr_bits(WORD_W);

    line_t             cs_line;
    line_t             ck_line;
    logic              sel_s;
    logic [WORD_W-1:0] word_q;
    logic [PW-1:0]     ptr_q;

    srp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cs_sync (
        .clk(clk), .rst(rst), .d(csn_in), .q(cs_line)
    );

    srp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_ck_sync (
        .clk(clk), .rst(rst), .d(sclk_in), .q(ck_line)
    );

    assign sel_s = ~cs_line.lvl;

    srp_hold #(.W(WORD_W)) i_hold (
        .clk(clk), .rst(rst), .load(res_load), .din(res_word),
        .frz(dec_off), .sel(sel_s), .word_q(word_q), .irq_q(irq_pull)
    );

    srp_ptr #(.W(WORD_W), .PW(PW)) i_ptr (
        .clk(clk), .rst(rst), .sel(sel_s), .adv(ck_line.rise),
        .frz(dec_off), .word(word_q), .ptr_q(ptr_q),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

endmodule

// File: rtl/srp_chk.sv
module srp_chk
    import srp_pkg::*;
#(
    parameter int W  = 6,
    parameter int PW = ptr_bits(W)
) (
    input logic          clk,
    input logic          rst,
    input logic          csn_in,
    input logic          load,
    input logic          frz,
    input logic          sel,
    input logic [W-1:0]  word,
    input logic [PW-1:0] ptr,
    input logic          sdo,
    input logic          sdo_oe,
    input logic          irq_pull
);

    a_r2_load_raises_irq: assert property (@(posedge clk) disable iff (rst)
        (load && !frz && !sel) |=> irq_pull);

    a_r5_select_clears_irq: assert property (@(posedge clk) disable iff (rst)
        sel |=> !irq_pull);

    a_r6_word_held_while_selected: assert property (@(posedge clk) disable iff (rst)
        sel |=> $stable(word));

    a_r8_word_held_while_frozen: assert property (@(posedge clk) disable iff (rst)
        frz |=> $stable(word));

    a_r4_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && !frz && ptr == PW'(W)) |-> !sdo);

    a_r9_quiet_when_released: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sdo);

    // R10: with the default two-stage chain, enable follows a low select two clocks on
    a_r10_enable_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> !$past(csn_in, 2));

endmodule

bind serial_result_port srp_chk #(.W(WORD_W)) i_chk (
    .clk(clk), .rst(rst), .csn_in(csn_in), .load(res_load), .frz(dec_off),
    .sel(sel_s), .word(word_q), .ptr(ptr_q), .sdo(sdo), .sdo_oe(sdo_oe),
    .irq_pull(irq_pull)
);

// File: tb/test_serial_result_port.sv
module test_serial_result_port;

    localparam int PER = 10;
    localparam int W   = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] res_word = '0;
    logic         res_load = 1'b0;
    logic         dec_off = 1'b0;
    logic         csn_in = 1'b1;
    logic         sclk_in = 1'b0;
    logic         sdo, sdo_oe, irq_pull;

    int total = 0;
    int bad = 0;

    always #(PER/2) clk = ~clk;

    serial_result_port #(.WORD_W(W), .SYNC_STAGES(2)) i_serial_result_port (
        .clk(clk), .rst(rst), .res_word(res_word), .res_load(res_load),
        .dec_off(dec_off), .csn_in(csn_in), .sclk_in(sclk_in),
        .sdo(sdo), .sdo_oe(sdo_oe), .irq_pull(irq_pull)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, updated on each rising edge from the inputs.
    logic         m_c1 = 1, m_c2 = 1, m_k1 = 0, m_k2 = 0, m_k3 = 0;
    logic [W-1:0] m_word = '0, m_pword = '0;
    logic         m_irq = 0, m_pend = 0;
    int           m_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_c1 = 1; m_c2 = 1; m_k1 = 0; m_k2 = 0; m_k3 = 0;
            m_word = '0; m_pword = '0; m_irq = 0; m_pend = 0; m_cnt = 0;
        end else begin
            logic selected, rising;
            selected = !m_c2;
            rising = m_k2 && !m_k3;
            if (res_load && !dec_off) begin
                if (!selected) begin m_word = res_word; m_irq = 1; m_pend = 0; end
                else begin m_pend = 1; m_pword = res_word; end
            end else if (!dec_off && !selected && m_pend) begin
                m_word = m_pword; m_irq = 1; m_pend = 0;
            end
            if (selected) m_irq = 0;
            if (!selected) m_cnt = 0;
            else if (rising && m_cnt < W) m_cnt++;
            m_c2 = m_c1; m_c1 = csn_in;
            m_k3 = m_k2; m_k2 = m_k1; m_k1 = sclk_in;
        end
    end

    always begin
        @(posedge clk);
        #(PER/4);
        if (!rst) begin
            logic e_oe, e_sdo;
            e_oe = !m_c2;
            if (!e_oe) e_sdo = 0;
            else if (dec_off) e_sdo = m_word[W-1];
            else if (m_cnt < W) e_sdo = m_word[W-1-m_cnt];
            else e_sdo = 0;
            chk(sdo_oe == e_oe, "R9 model enable", sdo_oe, e_oe);
            chk(sdo == e_sdo, "R3 model data", sdo, e_sdo);
            chk(irq_pull == m_irq, "R2 model irq", irq_pull, m_irq);
        end
    end

    task automatic load(input logic [W-1:0] w);
        @(negedge clk);
        res_word = w;
        res_load = 1'b1;
        @(negedge clk);
        res_load = 1'b0;
    endtask

    // Host read: select, n serial clocks, optional mid-read load, deselect.
    task automatic host_read(input int n, input logic mid, input logic [W-1:0] mw,
                             output logic [7:0] got);
        got = '0;
        @(negedge clk);
        csn_in = 1'b0;
        @(posedge clk); #(PER/4);
        chk(sdo_oe == 1'b0, "R10 enable not yet", sdo_oe, 0);
        @(posedge clk); #(PER/4);
        chk(sdo_oe == 1'b1, "R10 enable after two", sdo_oe, 1);
        @(posedge clk); #(PER/4);
        chk(irq_pull == 1'b0, "R5 irq cleared", irq_pull, 0);
        if (mid) begin
            load(mw);
            repeat (2) @(negedge clk);
            chk(irq_pull == 1'b0, "R6 no irq while selected", irq_pull, 0);
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            got = {got[6:0], sdo};
            sclk_in = 1'b1;
            repeat (3) @(negedge clk);
            sclk_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        @(negedge clk);
        csn_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] got;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sdo_oe == 0, "R1 enable after reset", sdo_oe, 0);
        chk(irq_pull == 0, "R1 irq after reset", irq_pull, 0);
        host_read(6, 0, '0, got);
        chk(got[5:0] == 6'b000000, "R1 word after reset", got[5:0], 0);

        load(6'b110110);
        chk(irq_pull == 1, "R2 irq after load", irq_pull, 1);
        host_read(6, 0, '0, got);
        chk(got[5:0] == 6'b110110, "R3 msb first read", got[5:0], 6'b110110);
        chk(irq_pull == 0, "R5 irq stays clear", irq_pull, 0);

        load(6'b000111);
        load(6'b101011);
        host_read(8, 0, '0, got);
        chk(got[5:0] != 6'b000111, "R7 older word replaced", got[5:0], 6'b101011);
        chk(got == 8'b10101100, "R4 eight clock read", got, 8'b10101100);

        host_read(6, 1, 6'b010011, got);
        chk(got[5:0] == 6'b101011, "R6 word unchanged during read", got[5:0], 6'b101011);
        chk(irq_pull == 1, "R6 parked result raises irq", irq_pull, 1);
        host_read(6, 1, 6'b111000, got);
        chk(got[5:0] == 6'b010011, "R6 parked word applied", got[5:0], 6'b010011);
        host_read(6, 0, '0, got);
        chk(got[5:0] == 6'b111000, "R7 parked overwrite", got[5:0], 6'b111000);

        load(6'b100101);
        host_read(6, 0, '0, got);
        @(negedge clk);
        dec_off = 1'b1;
        load(6'b011010);
        chk(irq_pull == 0, "R8 refused load no irq", irq_pull, 0);
        host_read(6, 0, '0, got);
        chk(got[5:0] == 6'b111111, "R8 frozen line", got[5:0], 6'b111111);
        @(negedge clk);
        dec_off = 1'b0;
        host_read(6, 0, '0, got);
        chk(got[5:0] == 6'b100101, "R8 refused load kept old", got[5:0], 6'b100101);

        @(negedge clk);
        chk(sdo == 0 && sdo_oe == 0, "R9 quiet when released", {sdo, sdo_oe}, 0);
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule